// File: doc/BRIEF.md
# Legacy Target ID Scan Sequencer

This block runs on the host side of a parallel SCSI bus during boot-time configuration. Once started, it walks the target IDs one at a time. For each ID it waits for the bus to be free, arbitrates with its own initiator ID, and selects that target. It then measures how many clock cycles the target takes to raise its busy response. A fast answer comes from a device whose ID is fixed by jumpers. A slow answer comes from a device that deliberately holds back before it answers its default ID, which marks it as auto-configurable. No answer at all means the ID is empty.

The bus itself is abstract. A free-bus flag, an arbitration request/grant pair, a select strobe with a target ID and a busy input stand in for the real signals. When the scan ends, two bitmaps are valid alongside the done flag. One holds the IDs taken by fixed-ID devices, which later assignment logic must not hand out. The other holds the IDs where a late-answering, configurable device responded. Both latency limits are parameters counted in clock cycles.

Top module: `legacy_id_scanner`

## Requirements
- R1: After reset the block is idle. `busy_o`, `done_o`, `arb_req_o` and `sel_o` are low, and both bitmaps read zero.
- R2: A `start_i` pulse while idle or done starts a scan. In the next cycle `busy_o` is high, `done_o` is low and both bitmaps are cleared.
- R3: A `start_i` pulse during a scan has no effect. `busy_o` stays high, the probe order continues unchanged and the final bitmaps are unchanged.
- R4: Target IDs are probed one at a time, in strictly descending order from NUM_TARGETS-1 (6) down to 0. Each ID gets exactly one selection, and `sel_id_o` carries the ID for as long as `sel_o` is high.
- R5: The block arbitrates with `arb_id_o` equal to HOST_ID (7). `arb_req_o` stays high until `arb_won_i` is seen. `sel_o` rises only in the cycle after a clock edge where both `arb_req_o` and `arb_won_i` are high.
- R6: Latency is the number of earlier rising edges of the current selection at which `sel_o` was high. If `bsy_i` is first seen with a latency below FAST_CYC, bit `id` of `legacy_map_o` is set.
- R7: If `bsy_i` is first seen with a latency from FAST_CYC to TIMEOUT_CYC-1, bit `id` of `cfg_map_o` is set and the legacy bit stays clear.
- R8: If `bsy_i` is not seen within TIMEOUT_CYC cycles of selection, `sel_o` falls after being high for exactly TIMEOUT_CYC cycles. Neither bitmap bit is set for that ID.
- R9: Between probes, `sel_o` is released. The next arbitration starts only after `bsy_i` is low and `bus_free_i` has been seen high.
- R10: After ID 0 is probed, `done_o` goes high and `busy_o` goes low. Both bitmaps then hold steady until the next start. No ID is ever set in both bitmaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a scan (taken when idle or done) |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Scan finished; bitmaps valid |
| legacy_map_o | output | 7 | IDs held by fixed-ID devices |
| cfg_map_o | output | 7 | IDs where a late-answering configurable device responded |
| bus_free_i | input | 1 | Bus is in the free phase |
| arb_req_o | output | 1 | Request arbitration |
| arb_id_o | output | 3 | Initiator ID used for arbitration |
| arb_won_i | input | 1 | Arbitration granted |
| sel_o | output | 1 | Selection of the target in `sel_id_o` |
| sel_id_o | output | 3 | Target ID being probed |
| bsy_i | input | 1 | Busy response from the selected target |

## Verification
The hardest situations to reach are the latency boundaries: an answer exactly one cycle before the fast limit, exactly at it, on the last cycle before the timeout, and exactly at the timeout. Each needs `bsy_i` to rise on a precise edge inside a selection whose start depends on random bus-free and arbitration delays. The bench models each target's answer delay relative to the first cycle it sees `sel_o` high, so a chosen latency lands on the intended edge whatever happened before. Directed scans place all four boundary values on different IDs. Random scans mix the three classes under random bus-free and grant stalls.

// File: rtl/scan_pkg.sv
// Package: shared types for the legacy ID scan sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package scan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_BUSFREE = 3'd1,
        ST_ARB     = 3'd2,
        ST_SEL     = 3'd3,
        ST_RELEASE = 3'd4,
        ST_DONE    = 3'd5
    } scan_state_e;

endpackage

// File: rtl/scan_latency_timer.sv
// Module: scan_latency_timer
// Counts the cycles spent in a selection and flags whether the count is still
// below the fast-answer limit and whether it has reached the timeout.
// Assumes: 0 < FAST_CYC < TIMEOUT_CYC. run_i is low for at least one cycle
// between selections, which clears the count.
module scan_latency_timer #(
    parameter int FAST_CYC    = 40,
    parameter int TIMEOUT_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic early_o,
    output logic expired_o
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_CYC);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count cycles while running, hold at the last value, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST_CNT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Decode the two limits from the running count.
    always_comb begin
        early_o   = (cnt_q < FAST_LIM);
        expired_o = (cnt_q == LAST_CNT);
    end

endmodule

// File: rtl/scan_id_map.sv
// Module: scan_id_map
// Holds one legacy bit and one configurable bit per target ID. The maps are
// cleared when a scan starts and updated by one record per probe.
// Assumes: rec_id_i < NUM_TARGETS whenever rec_i is high.
module scan_id_map #(
    parameter int NUM_TARGETS = 7,
    parameter int ID_W        = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear_i,
    input  logic                   rec_i,
    input  logic                   rec_legacy_i,
    input  logic [ID_W-1:0]        rec_id_i,
    output logic [NUM_TARGETS-1:0] legacy_map_o,
    output logic [NUM_TARGETS-1:0] cfg_map_o
);
    for (genvar g = 0; g < NUM_TARGETS; g++) begin : g_bit
        logic hit;

        // Match a record to this bit's ID.
        always_comb hit = rec_i && (rec_id_i == ID_W'(g));

        // Store this ID's class; a start clears both bits.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
                legacy_map_o[g] <= 1'b0;
                cfg_map_o[g]    <= 1'b0;
            end else if (hit) begin
                legacy_map_o[g] <= rec_legacy_i;
                cfg_map_o[g]    <= !rec_legacy_i;
            end
        end
    end

endmodule

// File: rtl/scan_ctrl.sv
// Module: scan_ctrl
// Sequencer: waits for a free bus, arbitrates, selects one target ID, and
// classifies the answer using the latency timer flags. It then releases the
// bus and moves to the next lower ID until ID 0 is done.
// Assumes: bus inputs are synchronous to clk.
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int NUM_TARGETS = 7,
    parameter int ID_W        = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            bus_free_i,
    input  logic            arb_won_i,
    input  logic            bsy_i,
    input  logic            early_i,
    input  logic            expired_i,
    output scan_state_e     state_o,
    output logic [ID_W-1:0] cur_id_o,
    output logic            clear_o,
    output logic            rec_o,
    output logic            rec_legacy_o
);
    localparam logic [ID_W-1:0] TOP_ID = ID_W'(NUM_TARGETS - 1);

    scan_state_e     state_q, state_d;
    logic [ID_W-1:0] id_q, id_d;

    // Next-state, ID-step and record logic.
    always_comb begin
        state_d      = state_q;
        id_d         = id_q;
        clear_o      = 1'b0;
        rec_o        = 1'b0;
        rec_legacy_o = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    clear_o = 1'b1;
                    id_d    = TOP_ID;
                    state_d = ST_BUSFREE;
                end
            end
            ST_BUSFREE: begin
                if (bus_free_i) state_d = ST_ARB;
            end
            ST_ARB: begin
                if (arb_won_i) state_d = ST_SEL;
            end
            ST_SEL: begin
                if (bsy_i) begin
                    rec_o        = 1'b1;
                    rec_legacy_o = early_i;
                    state_d      = ST_RELEASE;
                end else if (expired_i) begin
                    state_d = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                if (!bsy_i) begin
                    if (id_q == '0) begin
                        state_d = ST_DONE;
                    end else begin
                        id_d    = id_q - 1'b1;
                        state_d = ST_BUSFREE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and current-ID registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            id_q    <= id_d;
        end
    end

    // Export registered state and ID.
    always_comb begin
        state_o  = state_q;
        cur_id_o = id_q;
    end

endmodule

// File: rtl/legacy_id_scanner.sv
// Module: legacy_id_scanner (top)
// Probes each target ID from high to low and sorts it into fixed-ID,
// configurable or absent by how long the target takes to answer selection.
// All outputs are decoded from registered state (Moore).
// Assumes: FAST_CYC < TIMEOUT_CYC, HOST_ID >= NUM_TARGETS, synchronous inputs.
module legacy_id_scanner
    import scan_pkg::*;
#(
    parameter int NUM_TARGETS = 7,
    parameter int HOST_ID     = 7,
    parameter int FAST_CYC    = 40,
    parameter int TIMEOUT_CYC = 100,
    localparam int ID_W       = $clog2(HOST_ID + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [NUM_TARGETS-1:0] legacy_map_o,
    output logic [NUM_TARGETS-1:0] cfg_map_o,
    input  logic                   bus_free_i,
    output logic                   arb_req_o,
    output logic [ID_W-1:0]        arb_id_o,
    input  logic                   arb_won_i,
    output logic                   sel_o,
    output logic [ID_W-1:0]        sel_id_o,
    input  logic                   bsy_i
);
    scan_state_e     state;
    logic [ID_W-1:0] cur_id;
    logic            clear, rec, rec_legacy, early, expired;

    scan_ctrl #(.NUM_TARGETS(NUM_TARGETS), .ID_W(ID_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .bus_free_i(bus_free_i), .arb_won_i(arb_won_i), .bsy_i(bsy_i),
        .early_i(early), .expired_i(expired),
        .state_o(state), .cur_id_o(cur_id), .clear_o(clear),
        .rec_o(rec), .rec_legacy_o(rec_legacy)
    );

    scan_latency_timer #(.FAST_CYC(FAST_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run_i(state == ST_SEL),
        .early_o(early), .expired_o(expired)
    );

    scan_id_map #(.NUM_TARGETS(NUM_TARGETS), .ID_W(ID_W)) u_map (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .rec_i(rec),
        .rec_legacy_i(rec_legacy), .rec_id_i(cur_id),
        .legacy_map_o(legacy_map_o), .cfg_map_o(cfg_map_o)
    );

    // Decode bus and handshake outputs from the sequencer state.
    always_comb begin
        busy_o    = (state != ST_IDLE) && (state != ST_DONE);
        done_o    = (state == ST_DONE);
        arb_req_o = (state == ST_ARB);
        arb_id_o  = ID_W'(HOST_ID);
        sel_o     = (state == ST_SEL);
        sel_id_o  = cur_id;
    end

endmodule

// File: rtl/scan_checker.sv
// Module: scan_checker
// Protocol and timing properties of legacy_id_scanner, attached by bind.
module scan_checker #(
    parameter int NUM_TARGETS = 7,
    parameter int TIMEOUT_CYC = 100
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   busy_o,
    input logic                   done_o,
    input logic [NUM_TARGETS-1:0] legacy_map_o,
    input logic [NUM_TARGETS-1:0] cfg_map_o,
    input logic                   bus_free_i,
    input logic                   arb_req_o,
    input logic                   arb_won_i,
    input logic                   sel_o,
    input logic                   bsy_i
);
    logic [31:0] sel_run;

    // Count consecutive selection cycles for the timeout window.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_o) sel_run <= '0;
        else                  sel_run <= sel_run + 1;
    end

    // R5
    sel_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_o) |-> $past(arb_req_o && arb_won_i));

    // R9
    arb_after_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_req_o) |-> ($past(bus_free_i) && !$past(bsy_i)));

    // R8
    sel_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_run <= TIMEOUT_CYC);

    // R2
    clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (legacy_map_o == '0 && cfg_map_o == '0 && !done_o));

    // R10
    map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(done_o)) |-> ($stable(legacy_map_o) && $stable(cfg_map_o)));

    // R10
    map_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_map_o & cfg_map_o) == '0);

    // R4
    one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arb_req_o, sel_o, done_o}));

endmodule

bind legacy_id_scanner scan_checker #(
    .NUM_TARGETS(NUM_TARGETS), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_scan_checker (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
    .legacy_map_o(legacy_map_o), .cfg_map_o(cfg_map_o),
    .bus_free_i(bus_free_i), .arb_req_o(arb_req_o), .arb_won_i(arb_won_i),
    .sel_o(sel_o), .bsy_i(bsy_i)
);

// File: tb/test_legacy_id_scanner.sv
module test_legacy_id_scanner;
    localparam int NT   = 7;
    localparam int FAST = 40;
    localparam int TMO  = 100;
    localparam int NEVER = 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          bus_free_i = 1'b0;
    logic          arb_won_i = 1'b0;
    logic          bsy_i = 1'b0;
    logic          busy_o, done_o, arb_req_o, sel_o;
    logic [NT-1:0] legacy_map_o, cfg_map_o;
    logic [2:0]    arb_id_o, sel_id_o;

    int tests = 0;
    int fails = 0;
    int delay_q [NT];
    int probes = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    legacy_id_scanner #(.NUM_TARGETS(NT), .HOST_ID(7), .FAST_CYC(FAST), .TIMEOUT_CYC(TMO))
    i_legacy_id_scanner (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
        .legacy_map_o(legacy_map_o), .cfg_map_o(cfg_map_o), .bus_free_i(bus_free_i),
        .arb_req_o(arb_req_o), .arb_id_o(arb_id_o), .arb_won_i(arb_won_i),
        .sel_o(sel_o), .sel_id_o(sel_id_o), .bsy_i(bsy_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_legacy();
        int m = 0;
        for (int i = 0; i < NT; i++) if (delay_q[i] < FAST) m |= (1 << i);
        return m;
    endfunction

    function automatic int exp_cfg();
        int m = 0;
        for (int i = 0; i < NT; i++)
            if (delay_q[i] >= FAST && delay_q[i] < TMO) m |= (1 << i);
        return m;
    endfunction

    function automatic int pick_delay(input int kind);
        case (kind)
            0:       return int'($urandom % FAST);
            1:       return FAST + int'($urandom % (TMO - FAST));
            default: return ($urandom % 2) ? NEVER : TMO + int'($urandom % 20);
        endcase
    endfunction

    // Bus and target model: free flag, grant, and per-ID delayed busy answer.
    initial begin
        int k = 0;
        int id = 0;
        int sel_len = 0;
        bit in_sel = 0;
        bit in_arb = 0;
        forever begin
            @(negedge clk);
            bus_free_i = ($urandom % 4) != 0;
            arb_won_i  = arb_req_o && (($urandom % 3) == 0);
            if (arb_req_o && !in_arb)
                // R5: arbitration uses the host ID 7
                check(arb_id_o == 3'd7, "R5", "arbitration ID", arb_id_o, 7);
            in_arb = arb_req_o;
            if (sel_o && !in_sel) begin
                id = sel_id_o;
                // R4: probe order strictly descending from 6
                check(id == NT - 1 - probes, "R4", "probed ID", id, NT - 1 - probes);
                probes++;
                k = 0;
                sel_len = 0;
            end
            if (sel_o) begin
                sel_len++;
                if (k >= delay_q[id]) bsy_i = 1'b1;
                else k++;
            end else begin
                if (in_sel && delay_q[id] >= TMO)
                    // R8: no answer leaves selection up for exactly the timeout
                    check(sel_len == TMO, "R8", "selection length", sel_len, TMO);
                bsy_i = 1'b0;
            end
            in_sel = sel_o;
        end
    end

    task automatic run_scan(input bit poke_start);
        int guard = 0;
        probes = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R2: scan begins, maps cleared
        check(busy_o && !done_o, "R2", "busy after start", busy_o, 1);
        check(legacy_map_o == '0 && cfg_map_o == '0, "R2", "maps cleared",
              int'(legacy_map_o | cfg_map_o), 0);
        if (poke_start) begin
            repeat (150) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            @(negedge clk);
            // R3: start during scan ignored
            check(busy_o == 1'b1, "R3", "busy after mid-scan start", busy_o, 1);
        end
        while (!done_o && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(done_o && !busy_o, "R10", "done after last probe", done_o, 1);
        check(probes == NT, "R4", "probe count", probes, NT);
        // R6: fixed-ID devices
        check(int'(legacy_map_o) == exp_legacy(), "R6", "legacy map",
              legacy_map_o, exp_legacy());
        // R7: configurable devices
        check(int'(cfg_map_o) == exp_cfg(), "R7", "configurable map",
              cfg_map_o, exp_cfg());
        repeat (5) @(negedge clk);
        // R10: results hold while done
        check(done_o && int'(legacy_map_o) == exp_legacy() && int'(cfg_map_o) == exp_cfg(),
              "R10", "maps held", legacy_map_o, exp_legacy());
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NT; i++) delay_q[i] = NEVER;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!busy_o && !done_o && !arb_req_o && !sel_o, "R1", "idle outputs",
              int'({busy_o, done_o, arb_req_o, sel_o}), 0);
        check(legacy_map_o == '0 && cfg_map_o == '0, "R1", "maps at reset",
              int'(legacy_map_o | cfg_map_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: boundaries on distinct IDs (R6, R7, R8)
        delay_q[6] = FAST - 1; delay_q[5] = FAST; delay_q[4] = TMO - 1;
        delay_q[3] = TMO;      delay_q[2] = 0;    delay_q[1] = NEVER;
        delay_q[0] = FAST + 1;
        run_scan(0);

        // Directed: every ID fixed, then every ID empty
        for (int i = 0; i < NT; i++) delay_q[i] = i;
        run_scan(0);
        for (int i = 0; i < NT; i++) delay_q[i] = NEVER;
        run_scan(1);

        // Random mixes, one with a start pulse mid-scan (R3)
        for (int s = 0; s < 8; s++) begin
            for (int i = 0; i < NT; i++) delay_q[i] = pick_delay(int'($urandom % 3));
            run_scan(s == 2);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule